// File: doc/BRIEF.md
# Whole-Register Vector Transfer Sequencer

This block carries out one whole-register vector memory instruction at a time. It takes a 32-bit instruction word, a scalar base address and a resumable element index. It then moves a group of 1, 2, 4 or 8 consecutive vector registers between a byte-addressed memory port and an external vector register file, one element per memory beat. The configured vector length and element type play no part. A load transfers elements of the width encoded in the instruction. A store always moves plain bytes.

The element index (the running start position) is loaded from `vstart_in` when an instruction is accepted. It goes up by one for every element completed and is cleared when the instruction finishes. A transfer can therefore resume partway through a register. A register group that is not aligned to its own size is rejected with a one-cycle `illegal` pulse. An instruction word that does not match the whole-register encoding is ignored.

The memory side uses a valid/ready request channel and a separate load-response channel, with at most one request in flight. The register file side has a byte-wide combinational read port, used for stores, and a write port with byte enables, used for loads.

Top module: `vreg_whole_xfer`

## Requirements
- R1: A word is recognised only when all of these hold:
  - bits 6:0 are 0x07 (load) or 0x27 (store);
  - bits 28:26 are 000, bit 25 is 1 and bits 24:20 are 01000;
  - bits 14:12 are 0, 5, 6 or 7 for a load, or 0 for a store.

  Any other word raises no busy, no done, no illegal pulse and no memory request.
- R2: Bits 31:29 (nf) give the register count nf+1. Only nf values 0, 1, 3 and 7 are legal. Any other value gives a one-cycle `illegal` pulse one cycle after `start`, with no busy, no done and no access.
- R3: The register number in bits 11:7 must be a multiple of the register count. Otherwise the block raises `illegal` exactly as in R2.
- R4: A load's element size follows bits 14:12: 0 gives 1 byte, 5 gives 2, 6 gives 4 and 7 gives 8. `mem_req_size` carries log2 of that size. Each register holds VLENB/size elements, and a total of count×VLENB/size elements are moved. Each response is written to the register file with the low `size` byte enables set.
- R5: A store issues only 1-byte requests (`mem_req_size`=0), VLENB per register. Each request carries the register-file byte addressed by `rf_rreg`/`rf_rpos`.
- R6: Element k is requested at base + k×size, where k is the running index.
- R7: Element k belongs to register (number + k/epr) at position k mod epr, where epr is the number of elements per register. The transfer starts at k = `vstart_in`, so elements below it are left untouched.
- R8: If `vstart_in` is at or beyond the total, no request is issued and the instruction still completes.
- R9: `vstart_out` rises by exactly one per element and is 0 after completion. `done` is a one-cycle pulse in the cycle `busy` falls.
- R10: A request that is not accepted holds its address until `mem_req_ready`. No new load request is issued while a load response is pending.
- R11: After reset, `busy`, `done`, `illegal`, `mem_req_valid` and `rf_we` are low and `vstart_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Offer an instruction while idle |
| insn | input | 32 | Instruction word |
| base_addr | input | AW | Scalar base address |
| vstart_in | input | VSW | Starting element index |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle rejection pulse |
| vstart_out | output | VSW | Running element index |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | AW | Request byte address |
| mem_req_size | output | 2 | log2 of request bytes |
| mem_req_wdata | output | 64 | Write data, byte in low lane |
| mem_rsp_valid | input | 1 | Load data valid |
| mem_rsp_rdata | input | 64 | Load data, little-endian |
| rf_we | output | 1 | Register file write strobe |
| rf_wreg | output | RW | Register written |
| rf_wpos | output | LB | Element position written |
| rf_wbe | output | 8 | Byte enables of the element |
| rf_wdata | output | 64 | Element data |
| rf_rreg | output | RW | Register read for a store |
| rf_rpos | output | LB | Byte position read |
| rf_rdata | input | 8 | Byte read from the register file |

## Verification
Loads are run at all four element widths over all four group sizes. Because each case moves a full group, a wrong elements-per-register split shows up as missing or overlapping bytes. Resumed loads and stores begin mid-register at a nonzero index, which separates a correct register/position split from one that restarts at position 0 or at the base address. A start index at the total length confirms completion with no access. Malformed nf, a misaligned group and unrecognised words tell the illegal path apart from the ignore path. The memory model accepts requests only every other cycle, which exercises request hold.

// File: rtl/vreg_whole_xfer.sv
module vreg_whole_xfer #(
  parameter int VLENB = 8,
  parameter int NVREG = 32,
  parameter int AW    = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [31:0]                       insn,
  input  logic [AW-1:0]                     base_addr,
  input  logic [$clog2(8*VLENB):0]          vstart_in,
  output logic                              busy,
  output logic                              done,
  output logic                              illegal,
  output logic [$clog2(8*VLENB):0]          vstart_out,
  output logic                              mem_req_valid,
  input  logic                              mem_req_ready,
  output logic                              mem_req_we,
  output logic [AW-1:0]                     mem_req_addr,
  output logic [1:0]                        mem_req_size,
  output logic [63:0]                       mem_req_wdata,
  input  logic                              mem_rsp_valid,
  input  logic [63:0]                       mem_rsp_rdata,
  output logic                              rf_we,
  output logic [$clog2(NVREG)-1:0]          rf_wreg,
  output logic [$clog2(VLENB)-1:0]          rf_wpos,
  output logic [7:0]                        rf_wbe,
  output logic [63:0]                       rf_wdata,
  output logic [$clog2(NVREG)-1:0]          rf_rreg,
  output logic [$clog2(VLENB)-1:0]          rf_rpos,
  input  logic [7:0]                        rf_rdata
);
  localparam int LB  = $clog2(VLENB);
  localparam int RW  = $clog2(NVREG);
  localparam int VSW = $clog2(8*VLENB) + 1;

  logic [2:0] nf, wid;
  logic       is_ld, is_st, hit, nf_ok, aligned, bad, accept;
  assign nf      = insn[31:29];
  assign wid     = insn[14:12];
  assign is_ld   = insn[6:0] == 7'h07;
  assign is_st   = insn[6:0] == 7'h27;
  assign hit     = (is_ld | is_st) && insn[28:20] == 9'b000_1_01000 &&
                   (is_ld ? (wid == 3'd0 || wid >= 3'd5) : wid == 3'd0);
  assign nf_ok   = nf == 3'd0 || nf == 3'd1 || nf == 3'd3 || nf == 3'd7;
  assign aligned = (insn[9:7] & nf) == 3'd0;
  assign bad     = hit && !(nf_ok && aligned);
  assign accept  = start && !busy && hit && !bad;

  logic          st_q, wait_rsp, done_q, ill_q;
  logic [1:0]    sz_q;
  logic [2:0]    nf_q;
  logic [RW-1:0] vr_q;
  logic [AW-1:0] base_q;
  logic [VSW-1:0] vst;

  logic [VSW-1:0] cnt_w, total, epr_m, posw;
  logic [4:0]     eshift;
  logic [RW-1:0]  ereg;
  logic [8:0]     be_w;
  logic           fin;

  assign cnt_w  = VSW'({1'b0, nf_q} + 4'd1);
  assign total  = (cnt_w << LB) >> sz_q;
  assign eshift = 5'(LB) - {3'b0, sz_q};
  assign epr_m  = (VSW'(VLENB) >> sz_q) - VSW'(1);
  assign posw   = vst & epr_m;
  assign ereg   = vr_q + RW'(vst >> eshift);
  assign be_w   = (9'd1 << (4'd1 << sz_q)) - 9'd1;
  assign fin    = busy && !wait_rsp && vst >= total;

  assign mem_req_valid = busy && !wait_rsp && !fin;
  assign mem_req_we    = st_q;
  assign mem_req_size  = sz_q;
  assign mem_req_addr  = base_q + (AW'(vst) << sz_q);
  assign mem_req_wdata = {56'd0, rf_rdata};

  assign rf_we    = busy && wait_rsp && mem_rsp_valid;
  assign rf_wreg  = ereg;
  assign rf_wpos  = posw[LB-1:0];
  assign rf_wbe   = be_w[7:0];
  assign rf_wdata = mem_rsp_rdata;
  assign rf_rreg  = ereg;
  assign rf_rpos  = vst[LB-1:0];

  assign done       = done_q;
  assign illegal    = ill_q;
  assign vstart_out = vst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wait_rsp <= 1'b0;
      done_q   <= 1'b0;
      ill_q    <= 1'b0;
      st_q     <= 1'b0;
      sz_q     <= '0;
      nf_q     <= '0;
      vr_q     <= '0;
      base_q   <= '0;
      vst      <= '0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      if (!busy) begin
        if (start && bad) ill_q <= 1'b1;
        if (accept) begin
          busy     <= 1'b1;
          wait_rsp <= 1'b0;
          st_q     <= is_st;
          sz_q     <= is_st ? 2'd0 : wid[1:0];
          nf_q     <= nf;
          vr_q     <= RW'(insn[11:7]);
          base_q   <= base_addr;
          vst      <= vstart_in;
        end
      end else if (fin) begin
        busy   <= 1'b0;
        vst    <= '0;
        done_q <= 1'b1;
      end else if (wait_rsp) begin
        if (mem_rsp_valid) begin
          wait_rsp <= 1'b0;
          vst      <= vst + VSW'(1);
        end
      end else if (mem_req_ready) begin
        if (st_q) vst <= vst + VSW'(1);
        else      wait_rsp <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vreg_whole_xfer_chk.sv
module vreg_whole_xfer_chk #(
  parameter int AW  = 32,
  parameter int VSW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           illegal,
  input logic [VSW-1:0] vstart_out,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic           mem_req_we,
  input logic [AW-1:0]  mem_req_addr,
  input logic [1:0]     mem_req_size,
  input logic           rf_we
);
  a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r10_no_req_while_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !mem_req_valid);

  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vstart_out == '0 && !busy);

  a_r9_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r9_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && vstart_out != $past(vstart_out)
      |-> vstart_out == $past(vstart_out) + VSW'(1));

  a_r5_store_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_size == 2'd0);

  a_r2_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !busy && !done);
endmodule

bind vreg_whole_xfer vreg_whole_xfer_chk #(.AW(AW), .VSW(VSW)) u_chk (.*);

// File: tb/vreg_whole_xfer_bench.sv
`timescale 1ns/1ps
module vreg_whole_xfer_bench;
  localparam int VLENB = 8;
  localparam int NVREG = 32;
  localparam int AW    = 32;
  localparam int VSW   = $clog2(8*VLENB) + 1;
  localparam int RW    = $clog2(NVREG);
  localparam int LB    = $clog2(VLENB);

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic start = 0;
  logic [31:0] insn = '0;
  logic [AW-1:0] base_addr = '0;
  logic [VSW-1:0] vstart_in = '0;
  logic busy, done, illegal, mem_req_valid, mem_req_we, rf_we;
  logic [VSW-1:0] vstart_out;
  logic [AW-1:0] mem_req_addr;
  logic [1:0] mem_req_size;
  logic [63:0] mem_req_wdata, rf_wdata;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [63:0] mem_rsp_rdata = '0;
  logic [RW-1:0] rf_wreg, rf_rreg;
  logic [LB-1:0] rf_wpos, rf_rpos;
  logic [7:0] rf_wbe, rf_rdata;

  logic [7:0] mem [256];
  logic [7:0] rfm [NVREG*VLENB];
  assign rf_rdata = rfm[int'(rf_rreg)*VLENB + int'(rf_rpos)];

  vreg_whole_xfer #(.VLENB(VLENB), .NVREG(NVREG), .AW(AW)) u_vreg_whole_xfer (.*);

  int vectors = 0, miscompares = 0;
  int nreq, ndone, nill, szbad, holdbad, firstaddr, exp_sz;
  logic stall_q = 0;
  logic [AW-1:0] stall_addr;
  logic rsp_pend = 0;

  always @(posedge clk) begin
    mem_req_ready <= ~mem_req_ready;
    mem_rsp_valid <= 1'b0;
    if (done) ndone <= ndone + 1;
    if (illegal) nill <= nill + 1;
    if (stall_q && (!mem_req_valid || mem_req_addr != stall_addr)) holdbad <= holdbad + 1;
    stall_q <= mem_req_valid && !mem_req_ready;
    stall_addr <= mem_req_addr;
    if (rf_we) begin
      rsp_pend <= 1'b0;
      for (int b = 0; b < 8; b++)
        if (rf_wbe[b])
          rfm[int'(rf_wreg)*VLENB + (int'(rf_wpos) << exp_sz) + b] <= rf_wdata[8*b +: 8];
    end
    if (mem_req_valid && mem_req_ready) begin
      if (nreq == 0) firstaddr <= int'(mem_req_addr);
      nreq <= nreq + 1;
      if (int'(mem_req_size) != exp_sz) szbad <= szbad + 1;
      if (mem_req_we) mem[mem_req_addr[7:0]] <= mem_req_wdata[7:0];
      else begin
        if (rsp_pend) holdbad <= holdbad + 1;
        rsp_pend <= 1'b1;
        mem_rsp_valid <= 1'b1;
        for (int b = 0; b < 8; b++)
          mem_rsp_rdata[8*b +: 8] <= mem[8'(mem_req_addr[7:0] + 8'(b))];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] nf, input logic [2:0] w,
                                     input logic [4:0] vr, input bit st, input bit vm);
    return {nf, 3'b000, vm, 5'b01000, 5'd9, w, vr, st ? 7'h27 : 7'h07};
  endfunction

  task automatic run(input logic [31:0] iw, input int base, input int vs, input int sz);
    @(negedge clk);
    nreq = 0; ndone = 0; nill = 0; szbad = 0; firstaddr = -1; exp_sz = sz;
    insn = iw; base_addr = AW'(base); vstart_in = VSW'(vs); start = 1;
    @(negedge clk);
    start = 0;
    for (int t = 0; t < 500 && busy; t++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_load(input string tag, input int vd, input int nbytes, input int base, input int from);
    int bad = 0, fa = 0, fe = 0;
    for (int k = 0; k < nbytes; k++) begin
      int e = (k >= from) ? int'(mem[base + k]) : 8'hEE;
      if (int'(rfm[vd*VLENB + k]) != e && bad == 0) begin fa = rfm[vd*VLENB + k]; fe = e; end
      if (int'(rfm[vd*VLENB + k]) != e) bad++;
    end
    chk(bad == 0, tag, fa, fe);
  endtask

  task automatic preset_rf(input int vd, input int nbytes);
    for (int k = 0; k < nbytes; k++) rfm[vd*VLENB + k] = 8'hEE;
  endtask

  task automatic t_reset;
    chk(!busy && !done && !illegal && !mem_req_valid && !rf_we, "R11 idle outputs", int'(busy), 0);
    chk(vstart_out == 0, "R11 vstart", int'(vstart_out), 0);
  endtask

  task automatic t_load(input int nf, input int w, input int vd, input int base, input int sz);
    int regs = nf + 1;
    preset_rf(vd, regs*VLENB);
    run(mk(3'(nf), 3'(w), 5'(vd), 0, 1), base, 0, sz);
    chk_load($sformatf("R4 R7 load data nf=%0d w=%0d", nf, w), vd, regs*VLENB, base, 0);
    chk(nreq == regs*(VLENB >> sz), "R4 element count", nreq, regs*(VLENB >> sz));
    chk(szbad == 0 && firstaddr == base, "R6 size/first address", firstaddr, base);
    chk(ndone == 1 && vstart_out == 0, "R9 one done, vstart cleared", ndone, 1);
  endtask

  task automatic t_resume_load;
    preset_rf(6, 16);
    run(mk(3'd1, 3'd5, 5'd6, 0, 1), 'h80, 5, 1);
    chk_load("R7 resumed load", 6, 16, 'h80, 10);
    chk(nreq == 3 && firstaddr == 'h8A, "R6 R7 resumed first address", firstaddr, 'h8A);
  endtask

  task automatic t_past_end;
    preset_rf(12, 8);
    run(mk(3'd0, 3'd0, 5'd12, 0, 1), 'h30, 8, 0);
    chk(nreq == 0, "R8 no access", nreq, 0);
    chk(ndone == 1 && vstart_out == 0, "R8 completes, vstart cleared", ndone, 1);
    chk_load("R8 rf untouched", 12, 8, 'h30, 8);
  endtask

  task automatic t_store(input int nf, input int vd, input int base, input int vs);
    int bad = 0, fa = 0, fe = 0, n = (nf + 1)*VLENB;
    for (int k = 0; k < n; k++) mem[base + k] = 8'h00;
    run(mk(3'(nf), 3'd0, 5'(vd), 1, 1), base, vs, 0);
    for (int k = 0; k < n; k++) begin
      int e = (k >= vs) ? int'(rfm[vd*VLENB + k]) : 0;
      if (int'(mem[base + k]) != e && bad == 0) begin fa = mem[base + k]; fe = e; end
      if (int'(mem[base + k]) != e) bad++;
    end
    chk(bad == 0, $sformatf("R5 R7 store data vs=%0d", vs), fa, fe);
    chk(nreq == n - vs && szbad == 0, "R5 byte beats", nreq, n - vs);
    chk(firstaddr == base + vs, "R6 store first address", firstaddr, base + vs);
    chk(ndone == 1 && vstart_out == 0, "R9 store completion", ndone, 1);
  endtask

  task automatic t_reject(input logic [31:0] iw, input int exp_ill, input string tag);
    run(iw, 'h10, 0, 0);
    chk(nill == exp_ill, {tag, " illegal pulses"}, nill, exp_ill);
    chk(ndone == 0 && nreq == 0 && !busy, {tag, " no access"}, nreq, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i*7 + 3);
    for (int i = 0; i < NVREG*VLENB; i++) rfm[i] = 8'(i*13 + 1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_load(0, 0, 2, 'h10, 0);
    t_load(1, 5, 4, 'h20, 1);
    t_load(3, 6, 8, 'h30, 2);
    t_load(7, 7, 16, 'h40, 3);
    t_resume_load();
    t_past_end();
    t_store(1, 10, 'hA0, 0);
    t_store(7, 24, 'hC0, 60);
    t_reject(mk(3'd2, 3'd0, 5'd0, 0, 1), 1, "R2 nf=2");
    t_reject(mk(3'd1, 3'd0, 5'd3, 0, 1), 1, "R3 misaligned");
    t_reject(mk(3'd0, 3'd0, 5'd0, 0, 0), 0, "R1 vm=0");
    t_reject(mk(3'd0, 3'd1, 5'd0, 0, 1), 0, "R1 width=1");
    t_reject(mk(3'd0, 3'd5, 5'd0, 1, 1), 0, "R1 store width=5");
    chk(holdbad == 0, "R10 request hold / single outstanding", holdbad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule